// File: doc/BRIEF.md
# Paged Byte-Wide EEPROM Write Controller

This block models the write side of an 8192 x 8 parallel EEPROM. A host drives active-low chip-select, output-enable and write strobes with a 13-bit address and an 8-bit data bus. Write strobes place bytes into a 32-entry page holding area. When the strobes have stayed idle long enough after the last load, the block runs a timed internal programming phase. In that phase it copies the loaded bytes into an on-chip array. While the block is busy, a status output tells the host to wait, and reads return a polling pattern in place of array data. Every time interval is a parameter counted in clock cycles.

The data path is the bare strobe bus, not a valid/ready stream. A byte moves when its strobe pulse ends, and no ready signal pushes back. The host learns about back-pressure only from the busy output or from polling. Strobes that arrive while the block cannot take them are dropped, not held. All strobe inputs are treated as synchronous to `clk`.

Top module: `eep_page_writer`

## Requirements
- R1: A write strobe is active while chip-select and write-enable are both low and output-enable is high. The address is taken in the cycle the strobe becomes active. The data is taken in the cycle it becomes inactive. Address changes in between have no effect.
- R2: Address bits 4..0 pick a byte within a page. Bits 12..5 pick the page row. All loaded bytes are written to the row of the last byte loaded. Loading the same offset again replaces the earlier byte. One write can load 1 to 32 bytes.
- R3: After a byte has loaded, a new strobe that becomes active LOAD_LIMIT or more cycles later is ignored. Its byte is never written.
- R4: Programming starts after WINDOW consecutive cycles with no accepted strobe active, counted from the last data capture.
- R5: During programming, a read returns the complement of bit 7 of the last loaded byte on bit 7, and that byte's bits 6..0 on the lower bits.
- R6: `busy_pull` is 0 when idle. It goes to 1 the cycle after the first accepted strobe becomes active. It returns to 0 after PROG_CYCLES cycles of programming.
- R7: Write strobes that arrive during programming are ignored. The array keeps its contents.
- R8: Reset clears the page area and returns the block to idle with `busy_pull` at 0. Bytes loaded before reset are never programmed.
- R9: Programming writes only the offsets that were loaded. The other bytes of the row keep their old values.
- R10: With chip-select and output-enable low and write-enable high, `dout_en` is 1 and `dout` shows the array byte at `addr` (outside programming). `dout_en` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, blocks programming |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling pattern |
| dout_en | output | 1 | Read bus drive enable |
| busy_pull | output | 1 | 1 = status pin pulled low (busy), 0 = released |

## Verification
The bench builds the block with the full 13-bit array, LOAD_LIMIT = 20, WINDOW = 40 and PROG_CYCLES = 64. These values make each of the following happen within a few hundred cycles: the load window closing, a strobe rejected after the load limit, a read in the middle of programming, and the end of programming. The same values let many page writes run, each with 1 to 32 bytes at random offsets, so that rows overlap. That overlap makes it possible to check that unloaded bytes keep their earlier values.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_t;
endpackage

// File: rtl/eep_strobe.sv
// Write strobe tracker: combined strobe level, start/end pulses, address latch.
module eep_strobe #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              wr_start,
  output logic              wr_end,
  output logic [ADDR_W-1:0] addr_q
);
  logic act_q;

  // write strobe needs select and write low with the read enable high
  assign active   = ~ce_n & ~we_n & oe_n;
  assign wr_start = active & ~act_q;
  assign wr_end   = ~active & act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q <= active;
      if (wr_start) addr_q <= addr;
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
// Page holding area: one data register and one loaded flag per byte slot.
module eep_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [PAGE_BYTES-1:0] valid_mask
);
  logic [DATA_W-1:0] slot_data [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        valid_mask[g] <= 1'b0;
        slot_data[g]  <= '0;
      end else if (hit) begin
        valid_mask[g] <= 1'b1;
        slot_data[g]  <= wr_data;
      end
    end
  end

  assign rd_data  = slot_data[rd_idx];
  assign rd_valid = valid_mask[rd_idx];
endmodule

// File: rtl/eep_array.sv
// Non-volatile storage model: one write port, asynchronous read, no reset.
module eep_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 5,
  parameter int LOAD_LIMIT  = 3000,
  parameter int WINDOW      = 10000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy_pull
);
  import eep_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;
  localparam int TW         = $clog2(WINDOW + 1);
  localparam int PCW        = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0]  LIM_T  = TW'(LOAD_LIMIT);
  localparam logic [TW-1:0]  WIN_T  = TW'(WINDOW - 1);
  localparam logic [PCW-1:0] PEND_C = PCW'(PROG_CYCLES - 1);
  localparam logic [PCW-1:0] PB_C   = PCW'(PAGE_BYTES);

  eep_state_t        state;
  logic [TW-1:0]     timer;
  logic [PCW-1:0]    prog_cnt;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] last_q;
  logic              accepted;

  logic              active, wr_start, wr_end;
  logic [ADDR_W-1:0] addr_q;
  logic              accept_start, load_byte, prog_done;
  logic [PAGE_W-1:0] prog_idx;
  logic [DATA_W-1:0] slot_rd;
  logic              slot_ok;
  logic [PAGE_BYTES-1:0] buf_valid;
  logic              arr_we;
  logic [DATA_W-1:0] arr_rdata;

  eep_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .active(active), .wr_start(wr_start), .wr_end(wr_end), .addr_q(addr_q)
  );

  // a new strobe is taken when idle, or while loading inside the load limit
  assign accept_start = wr_start && (state != ST_PROG) &&
                        ((state == ST_IDLE) || (timer < LIM_T));
  assign load_byte    = wr_end && accepted;
  assign prog_done    = (state == ST_PROG) && (prog_cnt == PEND_C);
  assign prog_idx     = prog_cnt[PAGE_W-1:0];

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .clr(prog_done),
    .wr_en(load_byte), .wr_idx(addr_q[PAGE_W-1:0]), .wr_data(din),
    .rd_idx(prog_idx), .rd_data(slot_rd), .rd_valid(slot_ok),
    .valid_mask(buf_valid)
  );

  // one slot per cycle over the first PAGE_BYTES programming cycles
  assign arr_we = (state == ST_PROG) && (prog_cnt < PB_C) && slot_ok && !rst;

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr({row_q, prog_idx}), .wdata(slot_rd),
    .raddr(addr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      timer    <= '0;
      prog_cnt <= '0;
      row_q    <= '0;
      last_q   <= '0;
      accepted <= 1'b0;
    end else begin
      if (wr_start)    accepted <= accept_start;
      else if (wr_end) accepted <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          timer <= '0;
          if (accept_start) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (load_byte) begin
            timer  <= '0;
            row_q  <= addr_q[ADDR_W-1:PAGE_W];
            last_q <= din;
          end else if ((active && accepted) || accept_start) begin
            timer <= '0;
          end else if (timer == WIN_T) begin
            timer    <= '0;
            prog_cnt <= '0;
            state    <= (|buf_valid) ? ST_PROG : ST_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_PROG: begin
          prog_cnt <= prog_cnt + 1'b1;
          if (prog_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dout_en   = ~ce_n & ~oe_n & we_n;
  assign dout      = (state == ST_PROG) ? {~last_q[DATA_W-1], last_q[DATA_W-2:0]}
                                        : arr_rdata;
  assign busy_pull = (state != ST_IDLE);
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int TW         = 14,
  parameter int WINDOW     = 10000,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input logic                  clk,
  input logic                  rst,
  input eep_pkg::eep_state_t   state,
  input logic                  busy_pull,
  input logic                  dout_en,
  input logic [DATA_W-1:0]     dout,
  input logic [DATA_W-1:0]     last_q,
  input logic [TW-1:0]         timer,
  input logic [PAGE_BYTES-1:0] buf_valid,
  input logic                  arr_we,
  input logic [IDX_W-1:0]      prog_idx
);
  import eep_pkg::*;

  a_r6_busy_in_prog: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG) |-> busy_pull);

  a_r5_poll_bit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && dout_en) |-> (dout[DATA_W-1] != last_q[DATA_W-1]));

  a_r7_buf_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && $past(state) == ST_PROG) |-> $stable(buf_valid));

  a_r9_only_loaded: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> buf_valid[prog_idx]);

  a_r4_window_done: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && $past(state) == ST_LOAD) |-> ($past(timer) == TW'(WINDOW - 1)));

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      a_r8_reset_clean: assert (!busy_pull && buf_valid == '0);
    end
  end
endmodule

bind eep_page_writer eep_page_writer_chk #(
  .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .TW(TW), .WINDOW(WINDOW)
) u_chk (
  .clk(clk), .rst(rst), .state(state), .busy_pull(busy_pull), .dout_en(dout_en),
  .dout(dout), .last_q(last_q), .timer(timer), .buf_valid(buf_valid),
  .arr_we(arr_we), .prog_idx(prog_idx)
);

// File: tb/tb_eep_page_writer.sv
`timescale 1ns/1ps
module tb_eep_page_writer;
  localparam int AW = 13, DW = 8, PW = 5;
  localparam int LL = 20, WIN = 40, PC = 64;

  logic clk = 0, rst = 1;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy_pull;

  always #5 clk = ~clk;

  eep_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .LOAD_LIMIT(LL),
                    .WINDOW(WIN), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .busy_pull(busy_pull));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [DW-1:0] mem_m [1 << AW];
  bit known [1 << AW];
  logic [DW-1:0] pend [32];
  bit pv [32];
  logic [DW-1:0] last_b;

  function automatic logic [DW-1:0] poll_val(input logic [DW-1:0] b);
    return {~b[DW-1], b[DW-2:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_pend();
    for (int i = 0; i < 32; i++) pv[i] = 0;
  endtask

  task automatic commit(input logic [AW-PW-1:0] row);
    for (int i = 0; i < 32; i++)
      if (pv[i]) begin mem_m[{row, 5'(i)}] = pend[i]; known[{row, 5'(i)}] = 1; end
    clear_pend();
  endtask

  // mode 0: write-enable controlled, mode 1: chip-select controlled (R1)
  task automatic write_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit mode);
    @(negedge clk); addr = a; din = ~d; oe_n = 1;
    if (mode) begin we_n = 0; ce_n = 1; end else begin ce_n = 0; we_n = 1; end
    @(negedge clk); if (mode) ce_n = 0; else we_n = 0;
    @(negedge clk); addr = ~a; din = d;
    @(negedge clk); if (mode) ce_n = 1; else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1; addr = a;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit mode);
    write_byte(a, d, mode);
    pend[a[PW-1:0]] = d; pv[a[PW-1:0]] = 1; last_b = d;
  endtask

  task automatic read_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #2;
    chk(req, dout_en, 1);
    chk(req, dout, exp);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy_pull && k < 400) begin @(negedge clk); k++; end
    chk("R6 idle reached", busy_pull, 0);
  endtask

  task automatic check_row(input logic [AW-PW-1:0] row, input string req);
    for (int i = 0; i < 32; i++)
      if (known[{row, 5'(i)}]) read_check({row, 5'(i)}, mem_m[{row, 5'(i)}], req);
  endtask

  // full timing path after the last load: R4/R5/R6, optional R7 probe
  task automatic finish_page(input logic [AW-PW-1:0] row, input bit probe);
    repeat (WIN + 3) @(negedge clk);
    read_check({row, 5'd0}, poll_val(last_b), "R5 polling");
    if (probe) begin
      write_byte({row, 5'($urandom % 32)}, 8'($urandom), 1'($urandom));
      repeat (PC - 15) @(negedge clk);
    end else repeat (PC - 10) @(negedge clk);
    chk("R6 busy during programming", busy_pull, 1);
    repeat (12) @(negedge clk);
    chk("R6 released after programming", busy_pull, 0);
    commit(row);
  endtask

  initial begin
    clear_pend();
    for (int i = 0; i < (1 << AW); i++) known[i] = 0;
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", busy_pull, 0);
    rst = 0;
    @(negedge clk);
    chk("R6 idle after reset", busy_pull, 0);
    chk("R10 no drive when idle", dout_en, 0);

    // prefill rows 0..11 with full pages (R2 32 bytes)
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < 32; i++) load({8'(r), 5'(i)}, 8'($urandom), 1'(i % 2));
      finish_page(8'(r), 0);
      check_row(8'(r), "R2 full page");
    end

    // random partial pages over overlapping rows (R9, R7)
    for (int t = 0; t < 16; t++) begin
      automatic logic [7:0] row = 8'($urandom % 8);
      automatic int n = 1 + ($urandom % 32);
      for (int i = 0; i < n; i++) load({row, 5'($urandom % 32)}, 8'($urandom), 1'($urandom));
      finish_page(row, t % 2 == 1);
      check_row(row, "R9 unloaded bytes kept");
    end

    // R3: strobe past the load limit is dropped
    load({8'd9, 5'd0}, 8'h5A, 0);
    repeat (LL + 5) @(negedge clk);
    write_byte({8'd9, 5'd1}, ~mem_m[{8'd9, 5'd1}], 0);
    wait_idle();
    commit(8'd9);
    read_check({8'd9, 5'd1}, mem_m[{8'd9, 5'd1}], "R3 late strobe ignored");
    read_check({8'd9, 5'd0}, 8'h5A, "R3 first byte written");

    // R2: row of the last loaded byte wins
    load({8'd10, 5'd1}, 8'hC3, 1);
    load({8'd11, 5'd2}, 8'h3C, 0);
    wait_idle();
    commit(8'd11);
    check_row(8'd10, "R2 earlier row untouched");
    check_row(8'd11, "R2 bytes go to last row");

    // R8: reset discards loaded bytes
    write_byte({8'd4, 5'd3}, ~mem_m[{8'd4, 5'd3}], 0);
    clear_pend();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R8 busy cleared by reset", busy_pull, 0);
    repeat (WIN + PC + 10) @(negedge clk);
    chk("R8 no programming after reset", busy_pull, 0);
    read_check({8'd4, 5'd3}, mem_m[{8'd4, 5'd3}], "R8 old byte kept");

    // R10: drive enable decode
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; #2;
    chk("R10 no drive with write low", dout_en, 0);
    @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1; #2;
    chk("R10 no drive without select", dout_en, 0);
    @(negedge clk); oe_n = 1;
    repeat (WIN + 5) @(negedge clk);
    chk("R1 no write with output enable low", busy_pull, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule